// File: doc/BRIEF.md
# Multiplexed-Bus DMA Master Cycle Engine

This block is the part of a DMA engine that takes over a shared system bus and runs memory cycles on it. The engine hands it one transfer command at a time: direction, a 24-bit byte address, a lane-width hint, write data and a flag that marks the last transfer of a burst. Before driving any pin, the block asks for the bus with a hold request and waits until the host grants it. While it owns the bus it raises the address-enable line. It then puts the upper address byte on pins that also carry the upper data byte and pulses an address strobe high, so that an external latch captures that byte. The low 16 address bits have pins of their own.

After one more cycle with the address held stable, an active-low read or write strobe runs for at least a minimum number of clocks. A slow memory can stretch it by pulling a ready input low. A static mode input picks 8-bit or 16-bit bus operation. In 16-bit mode an active-low upper-byte enable, taken together with address bit 0, tells which byte lanes carry data. The even address always sits on the low lane. When not bus master, the block drives none of the shared pins. Every shared pin comes out as a value plus an output enable, and the tri-state buffer sits in the pad ring. Between transfers of a burst the bus stays owned. After the last one, the hold request and address enable drop.

Top module: `dmab_bus_master`

## Requirements
- R1: An accepted command raises hold_req_o in the next cycle. No pin is driven while hold_ack_i is low. The first clock edge that samples hold_ack_i high moves the block to bus master: in the following cycle addr_en_o and addr_stb_o are both 1.
- R2: In the cycle with addr_stb_o high, ad_hi_o carries address bits 23:16 (ad_hi_oe_o=1) and lo_addr_o carries bits 15:0. In the cycle after, addr_stb_o is 0, the address is unchanged and both memory strobes are still high. The strobe phase starts in the cycle after that.
- R3: mem_rd_n_o (read) or mem_wr_n_o (write) is low for at least STRB_MIN clock cycles, and the two are never low together.
- R4: While ready_i is sampled low at the clock edge, the active strobe stays low. With ready_i low during the first W strobe cycles, the strobe lasts max(STRB_MIN, W+1) cycles.
- R5: In 16-bit mode (word_mode_i=1), ube_n_o is driven and the lanes are set by address bit 0 and cmd_wide_i. Bit 0 = 0 with wide = 1 gives ube_n_o=0 and both lanes. Bit 0 = 1 gives ube_n_o=0 and the upper lane only. Bit 0 = 0 with wide = 0 gives ube_n_o=1 and the lower lane only.
- R6: In 8-bit mode (word_mode_i=0), ube_oe_o stays 0, only the low lane (dat_lo_*) carries data, and ad_hi_oe_o is 0 throughout the strobe phase.
- R7: For a write, low-lane data (cmd_wdata_i[7:0]) is on dat_lo_o whenever the low lane is valid. Upper data (cmd_wdata_i[15:8]) appears on ad_hi_o only in the strobe phase, after the address cycles, and only when the upper lane is valid.
- R8: For a read, the data pins are not driven in the strobe phase. At the clock edge that ends the strobe, rd_data_o captures {ad_hi_i, dat_lo_i}, and rd_valid_o is 1 for exactly the following cycle.
- R9: Whenever addr_en_o is 0, lo_addr_oe_o, ad_hi_oe_o, dat_lo_oe_o, ube_oe_o and strobe_oe_o are all 0.
- R10: In the cycle after the one that follows a transfer with cmd_last_i=1, hold_req_o and addr_en_o are 0. After a transfer without the flag, both stay 1 until the next command. That command starts at the address strobe, with no new handshake.
- R11: After reset, hold_req_o, addr_en_o, addr_stb_o, rd_valid_o and every output enable are 0, both strobes are 1, and cmd_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | Static bus width: 0 = 8-bit, 1 = 16-bit |
| cmd_valid_i | input | 1 | A transfer command is offered |
| cmd_ready_o | output | 1 | Command is taken at this clock edge |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_wide_i | input | 1 | 16-bit mode, even address: move both lanes |
| cmd_last_i | input | 1 | Last transfer of the burst |
| cmd_addr_i | input | 24 | Byte address |
| cmd_wdata_i | input | 16 | Write data, lane-aligned ([7:0] low lane) |
| rd_data_o | output | 16 | Read data, lane-aligned |
| rd_valid_o | output | 1 | Read data valid pulse |
| hold_req_o | output | 1 | Bus hold request |
| hold_ack_i | input | 1 | Bus hold grant |
| addr_en_o | output | 1 | Bus master address enable |
| addr_stb_o | output | 1 | Upper-address latch strobe, active high |
| lo_addr_o | output | 16 | Address bits 15:0 |
| lo_addr_oe_o | output | 1 | Output enable for lo_addr_o |
| ad_hi_o | output | 8 | Shared pins: address 23:16, then write data 15:8 |
| ad_hi_oe_o | output | 1 | Output enable for ad_hi_o |
| ad_hi_i | input | 8 | Shared pins, read data 15:8 |
| dat_lo_o | output | 8 | Write data 7:0 |
| dat_lo_oe_o | output | 1 | Output enable for dat_lo_o |
| dat_lo_i | input | 8 | Read data 7:0 |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| strobe_oe_o | output | 1 | Output enable for both strobes |
| ube_n_o | output | 1 | Upper-byte enable, active low |
| ube_oe_o | output | 1 | Output enable for ube_n_o |
| ready_i | input | 1 | Memory ready; low stretches the strobe |

## Verification
The bench targets four corner cases. The first is the boundary between address and data on the shared upper pins. A design that put write data there during the strobe cycle or the hold cycle would hand the external latch a wrong address. The second is strobe length when ready is low for zero, one, three and five cycles. A counter off by one would cut the pulse below the minimum or stretch it one cycle past the release. The third covers all three 16-bit lane encodings plus 8-bit mode. Swapping the odd-address and narrow cases would show the wrong byte enable or drive the wrong lane. The last is ownership across a burst with idle gaps. A block that dropped the hold request between commands, or kept it after the last one, would fail the release check in the cycle after the final transfer. The bench also changes its read inputs as soon as the strobe ends, so a design that samples read data one edge late picks up the wrong value.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_AHOLD,
        ST_STRB,
        ST_FIN,
        ST_GAP
    } dmab_state_e;

    typedef struct packed {
        logic ube_n;
        logic lo_v;
        logic hi_v;
    } dmab_lane_t;

endpackage

// File: rtl/dmab_lane_dec.sv
module dmab_lane_dec
    import dmab_pkg::*;
(
    input  logic       word_mode_i,
    input  logic       a0_i,
    input  logic       wide_i,
    output dmab_lane_t lane_o
);

    always_comb begin
        if (!word_mode_i) begin
            lane_o = '{ube_n: 1'b1, lo_v: 1'b1, hi_v: 1'b0};
        end else if (a0_i) begin
            lane_o = '{ube_n: 1'b0, lo_v: 1'b0, hi_v: 1'b1};
        end else if (wide_i) begin
            lane_o = '{ube_n: 1'b0, lo_v: 1'b1, hi_v: 1'b1};
        end else begin
            lane_o = '{ube_n: 1'b1, lo_v: 1'b1, hi_v: 1'b0};
        end
    end

endmodule

// File: rtl/dmab_strobe_timer.sv
module dmab_strobe_timer #(
    parameter int STRB_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ready_i,
    output logic done_o
);

    localparam int CW = (STRB_MIN < 2) ? 1 : $clog2(STRB_MIN);
    localparam logic [CW-1:0] LAST = CW'(STRB_MIN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (active_i) begin
            cnt_d = (cnt_q >= LAST) ? cnt_q : cnt_q + 1'b1;
        end
        done_o = active_i && (cnt_q >= LAST) && ready_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dmab_bus_master.sv
module dmab_bus_master
    import dmab_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LO_W     = 16,
    parameter int DATA_W   = 16,
    parameter int STRB_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_write_i,
    input  logic              cmd_wide_i,
    input  logic              cmd_last_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              hold_req_o,
    input  logic              hold_ack_i,
    output logic              addr_en_o,
    output logic              addr_stb_o,
    output logic [LO_W-1:0]   lo_addr_o,
    output logic              lo_addr_oe_o,
    output logic [ADDR_W-LO_W-1:0] ad_hi_o,
    output logic              ad_hi_oe_o,
    input  logic [ADDR_W-LO_W-1:0] ad_hi_i,
    output logic [DATA_W/2-1:0] dat_lo_o,
    output logic              dat_lo_oe_o,
    input  logic [DATA_W/2-1:0] dat_lo_i,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic              strobe_oe_o,
    output logic              ube_n_o,
    output logic              ube_oe_o,
    input  logic              ready_i
);

    localparam int LANE_W = DATA_W / 2;
    localparam int HI_W   = ADDR_W - LO_W;

    typedef struct packed {
        dmab_state_e       st;
        logic              wr;
        logic              last;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvld;
    } regs_t;

    regs_t      d, q;
    dmab_lane_t lane;
    logic       strb_done;
    logic       master, in_addr, in_data;

    dmab_lane_dec u_lane (
        .word_mode_i (word_mode_i),
        .a0_i        (q.addr[0]),
        .wide_i      (q.wide),
        .lane_o      (lane)
    );

    dmab_strobe_timer #(.STRB_MIN(STRB_MIN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (q.st == ST_STRB),
        .ready_i  (ready_i),
        .done_o   (strb_done)
    );

    always_comb begin
        d      = q;
        d.rvld = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_GAP: begin
                if (cmd_valid_i) begin
                    d.wr    = cmd_write_i;
                    d.last  = cmd_last_i;
                    d.wide  = cmd_wide_i;
                    d.addr  = cmd_addr_i;
                    d.wdata = cmd_wdata_i;
                    d.st    = (q.st == ST_IDLE) ? ST_REQ : ST_ADDR;
                end
            end
            ST_REQ:   if (hold_ack_i) d.st = ST_ADDR;
            ST_ADDR:  d.st = ST_AHOLD;
            ST_AHOLD: d.st = ST_STRB;
            ST_STRB: begin
                if (strb_done) begin
                    d.st = ST_FIN;
                    if (!q.wr) begin
                        d.rdata = {ad_hi_i, dat_lo_i};
                        d.rvld  = 1'b1;
                    end
                end
            end
            ST_FIN:   d.st = q.last ? ST_IDLE : ST_GAP;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        master  = (q.st == ST_ADDR) || (q.st == ST_AHOLD) || (q.st == ST_STRB)
               || (q.st == ST_FIN) || (q.st == ST_GAP);
        in_addr = (q.st == ST_ADDR) || (q.st == ST_AHOLD);
        in_data = (q.st == ST_STRB) || (q.st == ST_FIN);

        cmd_ready_o  = (q.st == ST_IDLE) || (q.st == ST_GAP);
        hold_req_o   = (q.st != ST_IDLE);
        addr_en_o    = master;
        addr_stb_o   = (q.st == ST_ADDR);
        lo_addr_o    = q.addr[LO_W-1:0];
        lo_addr_oe_o = master;
        ad_hi_o      = in_addr ? q.addr[ADDR_W-1:LO_W] : q.wdata[DATA_W-1:LANE_W];
        ad_hi_oe_o   = in_addr || (in_data && q.wr && lane.hi_v);
        dat_lo_o     = q.wdata[LANE_W-1:0];
        dat_lo_oe_o  = in_data && q.wr && lane.lo_v;
        mem_rd_n_o   = !((q.st == ST_STRB) && !q.wr);
        mem_wr_n_o   = !((q.st == ST_STRB) && q.wr);
        strobe_oe_o  = master;
        ube_n_o      = lane.ube_n;
        ube_oe_o     = master && word_mode_i;
        rd_data_o    = q.rdata;
        rd_valid_o   = q.rvld;
    end

    logic strobe_on;
    assign strobe_on = !mem_rd_n_o || !mem_wr_n_o;

    a_r1_master_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_en_o) |-> $past(hold_ack_i) && hold_req_o && addr_stb_o);

    a_r2_addr_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |=> !addr_stb_o && ad_hi_oe_o && mem_rd_n_o && mem_wr_n_o
                       && $stable(lo_addr_o) && $stable(ad_hi_o));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n_o && !mem_wr_n_o));

    generate
        if (STRB_MIN >= 2) begin : g_minw
            a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(strobe_on) |=> strobe_on);
        end
    endgenerate

    a_r4_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && !ready_i) |=> strobe_on);

    a_r6_byte_no_ube: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode_i |-> !ube_oe_o);

    a_r9_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en_o |-> !(lo_addr_oe_o || ad_hi_oe_o || dat_lo_oe_o || ube_oe_o || strobe_oe_o));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req_o) |-> !addr_en_o && $past(mem_rd_n_o) && $past(mem_wr_n_o));

endmodule

// File: tb/dmab_bus_master_tb_top.sv
module dmab_bus_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STRB_MIN   = 2;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b1;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_wide = 1'b0, cmd_last = 1'b0;
    logic [23:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_ready;
    logic [15:0] rd_data;
    logic        rd_valid, hold_req, addr_en, addr_stb;
    logic        hold_ack = 1'b0;
    logic [15:0] lo_addr;
    logic        lo_addr_oe;
    logic [7:0]  ad_hi_o, dat_lo_o;
    logic [7:0]  ad_hi_i = 8'h3C, dat_lo_i = 8'hC3;
    logic        ad_hi_oe, dat_lo_oe, mem_rd_n, mem_wr_n, strobe_oe, ube_n, ube_oe;
    logic        ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmab_bus_master #(.STRB_MIN(STRB_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
        .cmd_wide_i(cmd_wide), .cmd_last_i(cmd_last), .cmd_addr_i(cmd_addr),
        .cmd_wdata_i(cmd_wdata), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .hold_req_o(hold_req), .hold_ack_i(hold_ack), .addr_en_o(addr_en),
        .addr_stb_o(addr_stb), .lo_addr_o(lo_addr), .lo_addr_oe_o(lo_addr_oe),
        .ad_hi_o(ad_hi_o), .ad_hi_oe_o(ad_hi_oe), .ad_hi_i(ad_hi_i),
        .dat_lo_o(dat_lo_o), .dat_lo_oe_o(dat_lo_oe), .dat_lo_i(dat_lo_i),
        .mem_rd_n_o(mem_rd_n), .mem_wr_n_o(mem_wr_n), .strobe_oe_o(strobe_oe),
        .ube_n_o(ube_n), .ube_oe_o(ube_oe), .ready_i(ready)
    );

    typedef struct {
        bit          wr;
        bit          last;
        logic [23:0] addr;
        bit          ube_on;
        bit          ube_n;
        bit          lo_v;
        bit          hi_v;
        logic [15:0] wdata;
        int          len;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] rexp_q[$];
    int          n_chk = 0, n_fail = 0;
    int          wait_cfg = 0;
    int          ack_dly = 0;
    bit          finished = 1'b0;

    function automatic logic [7:0] mb(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // hold acknowledge responder, checks R1
    initial begin
        int  cnt = 0;
        bit  just = 1'b0;
        forever begin
            @(negedge clk);
            if (!hold_req) begin
                hold_ack = 1'b0;
                cnt = 0;
                just = 1'b0;
            end else if (!hold_ack) begin
                chk(!addr_en && !lo_addr_oe && !strobe_oe, "R1", "bus driven before grant",
                    {31'b0, addr_en}, 32'h0);
                if (cnt == ack_dly) begin
                    hold_ack = 1'b1;
                    just = 1'b1;
                end else begin
                    cnt++;
                end
            end else if (just) begin
                chk(addr_en && addr_stb, "R1", "master+strobe after grant",
                    {30'b0, addr_en, addr_stb}, 32'h3);
                just = 1'b0;
            end
        end
    end

    // bus monitor / memory model / scoreboard
    logic [23:0] lat_addr;
    bit          ahold_pend = 1'b0, rel_pend = 1'b0, rel_exp = 1'b0;
    bit          cap_ube_oe, cap_ube_n, cap_wr, cap_lo_oe, cap_hi_oe;
    logic [7:0]  cap_lo, cap_hi;
    int          k = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!addr_en)
                chk(!(lo_addr_oe || ad_hi_oe || dat_lo_oe || ube_oe || strobe_oe), "R9",
                    "enable while not master",
                    {27'b0, lo_addr_oe, ad_hi_oe, dat_lo_oe, ube_oe, strobe_oe}, 32'h0);
            if (rel_pend) begin
                chk(hold_req == rel_exp && addr_en == rel_exp, "R10", "bus ownership after transfer",
                    {30'b0, hold_req, addr_en}, {30'b0, rel_exp, rel_exp});
                rel_pend = 1'b0;
            end
            if (ahold_pend) begin
                chk(!addr_stb && ad_hi_oe && ad_hi_o == lat_addr[23:16] && mem_rd_n && mem_wr_n
                    && lo_addr == lat_addr[15:0], "R2", "address hold cycle",
                    {ad_hi_o, lo_addr}, lat_addr);
                ahold_pend = 1'b0;
            end
            if (addr_stb) begin
                chk(ad_hi_oe && mem_rd_n && mem_wr_n, "R2", "shared pins carry address",
                    {31'b0, ad_hi_oe}, 32'h1);
                lat_addr   = {ad_hi_o, lo_addr};
                cap_ube_oe = ube_oe;
                cap_ube_n  = ube_n;
                ahold_pend = 1'b1;
            end
            if (!mem_rd_n || !mem_wr_n) begin
                k++;
                if (k == 1) begin
                    cap_wr    = !mem_wr_n;
                    cap_lo_oe = dat_lo_oe;
                    cap_hi_oe = ad_hi_oe;
                    cap_lo    = dat_lo_o;
                    cap_hi    = ad_hi_o;
                    if (word_mode) begin
                        ad_hi_i  = mb(lat_addr | 24'h1);
                        dat_lo_i = mb(lat_addr & ~24'h1);
                    end else begin
                        ad_hi_i  = 8'h00;
                        dat_lo_i = mb(lat_addr);
                    end
                end
                ready = (k > wait_cfg);
            end else if (k > 0) begin
                exp_t e;
                ad_hi_i  = 8'h3C;
                dat_lo_i = 8'hC3;
                ready    = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected bus cycle", 32'h1, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cap_wr == e.wr, "R3", "strobe kind", {31'b0, cap_wr}, {31'b0, e.wr});
                    chk(lat_addr == e.addr, "R2", "latched address", lat_addr, e.addr);
                    chk(k == e.len, (wait_cfg > 0) ? "R4" : "R3", "strobe length", k, e.len);
                    chk(cap_ube_oe == e.ube_on && (!e.ube_on || cap_ube_n == e.ube_n),
                        e.ube_on ? "R5" : "R6", "ube enable/value",
                        {30'b0, cap_ube_oe, cap_ube_n}, {30'b0, e.ube_on, e.ube_n});
                    if (e.wr) begin
                        chk(cap_lo_oe == e.lo_v && cap_hi_oe == e.hi_v, "R7", "write lane enables",
                            {30'b0, cap_hi_oe, cap_lo_oe}, {30'b0, e.hi_v, e.lo_v});
                        if (e.lo_v) chk(cap_lo == e.wdata[7:0], "R7", "low lane write data",
                                        cap_lo, e.wdata[7:0]);
                        if (e.hi_v) chk(cap_hi == e.wdata[15:8], "R7", "upper lane write data",
                                        cap_hi, e.wdata[15:8]);
                    end else begin
                        chk(!cap_lo_oe && !cap_hi_oe, e.ube_on ? "R8" : "R6", "pins float on read",
                            {30'b0, cap_hi_oe, cap_lo_oe}, 32'h0);
                    end
                    rel_pend = 1'b1;
                    rel_exp  = !e.last;
                end
                k = 0;
            end
            if (rd_valid) begin
                if (rexp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected rd_valid", 32'h1, 32'h0);
                end else begin
                    logic [15:0] r;
                    r = rexp_q.pop_front();
                    chk(rd_data == r, "R8", "read data", rd_data, r);
                end
            end
        end
    end

    task automatic send(bit wr, logic [23:0] a, bit wide, logic [15:0] wd, bit last, int gap);
        exp_t e;
        repeat (gap) @(negedge clk);
        e.wr = wr; e.last = last; e.addr = a; e.wdata = wd;
        e.len = (wait_cfg + 1 > STRB_MIN) ? wait_cfg + 1 : STRB_MIN;
        if (!word_mode) begin
            e.ube_on = 0; e.ube_n = 1; e.lo_v = 1; e.hi_v = 0;
        end else if (a[0]) begin
            e.ube_on = 1; e.ube_n = 0; e.lo_v = 0; e.hi_v = 1;
        end else if (wide) begin
            e.ube_on = 1; e.ube_n = 0; e.lo_v = 1; e.hi_v = 1;
        end else begin
            e.ube_on = 1; e.ube_n = 1; e.lo_v = 1; e.hi_v = 0;
        end
        exp_q.push_back(e);
        if (!wr) rexp_q.push_back(word_mode ? {mb(a | 24'h1), mb(a & ~24'h1)} : {8'h00, mb(a)});
        cmd_write = wr; cmd_addr = a; cmd_wide = wide; cmd_wdata = wd; cmd_last = last;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (hold_req || exp_q.size() != 0 || rexp_q.size() != 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!hold_req && !addr_en && !addr_stb && !rd_valid, "R11", "reset control outputs",
            {28'b0, hold_req, addr_en, addr_stb, rd_valid}, 32'h0);
        chk(!lo_addr_oe && !ad_hi_oe && !dat_lo_oe && !strobe_oe && !ube_oe, "R11",
            "reset enables", {27'b0, lo_addr_oe, ad_hi_oe, dat_lo_oe, strobe_oe, ube_oe}, 32'h0);
        chk(mem_rd_n && mem_wr_n && cmd_ready, "R11", "reset strobes/ready",
            {29'b0, mem_rd_n, mem_wr_n, cmd_ready}, 32'h7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 16-bit mode, no wait states, mixed lanes (R5, R7, R8, R10)
        word_mode = 1'b1; wait_cfg = 0; ack_dly = 2;
        send(1'b1, 24'h123456, 1'b1, 16'hBEEF, 1'b0, 0);
        send(1'b0, 24'h123457, 1'b0, 16'h0000, 1'b0, 0);
        send(1'b1, 24'hABCDE0, 1'b0, 16'h77C1, 1'b1, 0);
        drain();

        // 16-bit mode, ready stretches strobe (R4), grant arrives at once
        wait_cfg = 3; ack_dly = 0;
        send(1'b0, 24'hFE0010, 1'b1, 16'h0000, 1'b0, 0);
        send(1'b1, 24'h00F0F1, 1'b0, 16'h5A00, 1'b1, 0);
        drain();

        // 8-bit mode (R6) with idle gaps inside the burst (R10)
        word_mode = 1'b0; wait_cfg = 1; ack_dly = 1;
        send(1'b1, 24'h80FF03, 1'b1, 16'hFF9C, 1'b0, 0);
        send(1'b0, 24'h80FF04, 1'b0, 16'h0000, 1'b0, 3);
        send(1'b0, 24'h0A0B0D, 1'b0, 16'h0000, 1'b1, 2);
        drain();

        // 16-bit narrow read at even address with long wait (R4, R5, R8)
        word_mode = 1'b1; wait_cfg = 5; ack_dly = 4;
        send(1'b0, 24'h4433A2, 1'b0, 16'h0000, 1'b1, 0);
        drain();

        // back-to-back bursts: release then new handshake
        wait_cfg = 0; ack_dly = 0;
        send(1'b1, 24'h000000, 1'b1, 16'h1234, 1'b1, 0);
        send(1'b0, 24'hFFFFFF, 1'b0, 16'h0000, 1'b1, 0);
        drain();

        chk(!hold_req && !addr_en, "R10", "bus released at end", {30'b0, hold_req, addr_en}, 32'h0);
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
        finish_run();
    end

endmodule